// File: doc/BRIEF.md
# Backdoor Security Key Comparator

This block lets a secured device be unlocked by software that knows a set of secret key words. Software sets a key-access mode bit. While that bit is set, word writes that land in a small key address window are captured as candidate keys instead of being treated as the start of a program or erase sequence. Each candidate is stored under the key index decoded from its address.

When software clears the mode bit, the captured set is compared as a whole against the stored key words. The comparison is only allowed to succeed if the key-enable bit, loaded at reset, is 1. On success the 2-bit security field is forced to the unsecured code 2'b10. On failure the field is left as it was and a one-cycle violation pulse goes to the CPU. The captured words are wiped after every comparison, so each attempt starts from nothing.

Top module: `sec_backdoor_unlock`

## Requirements
- R1: While reset is high and on the first cycle after it, `sec_state_o` equals `sec_reset_i` and `violation_o` is 0.
- R2: Suppose all four key words have been captured, each equals `stored_keys_i` at its index (key i lives in bits [16*i+15:16*i]), and `key_en_i` is 1. Then on the clock edge at which `key_acc_i` is seen falling, `sec_state_o` becomes 2'b10 and `violation_o` stays 0.
- R3: If any captured word differs from its stored key when `key_acc_i` falls, `sec_state_o` keeps its value and `violation_o` is 1 for the cycle after that edge.
- R4: A key index that has not been written since the last comparison counts as a mismatch.
- R5: With `key_en_i` at 0, a comparison never unlocks, even when all four keys are correct, and it raises the violation pulse.
- R6: Writes made while `key_acc_i` is 0 are not captured.
- R7: The captured words and their written markers are cleared after every comparison, so a later attempt that omits a word fails.
- R8: A write to an odd address, or to an address outside the window KEY_BASE..KEY_BASE+7, is ignored. Key index i is at byte address KEY_BASE+2*i.
- R9: A later write to the same key index replaces the earlier word.
- R10: Once `sec_state_o` is 2'b10 it stays 2'b10 until reset. A failed comparison still pulses `violation_o`.
- R11: `violation_o` is never high for two cycles in a row and is only high right after an exit from key-access mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_en_i | input | 1 | Reset-loaded key-enable bit |
| sec_reset_i | input | 2 | Value the security field loads on reset |
| key_acc_i | input | 1 | Key-access mode bit from software |
| wr_en_i | input | 1 | Bus word write strobe |
| wr_addr_i | input | ADDR_W | Bus byte address |
| wr_data_i | input | KEY_W | Bus write data |
| stored_keys_i | input | NUM_KEYS*KEY_W | Stored key words, index i at [KEY_W*i +: KEY_W] |
| sec_state_o | output | 2 | Security field, 2'b10 means unsecured |
| violation_o | output | 1 | One-cycle security violation pulse |

## Verification
The bench builds the block with its defaults: four 16-bit keys, a 16-bit address and the window based at 0xFF00. With these values the bench can write to an odd address inside the window (0xFF03) and to the first word past the window (0xFF08), and can check that neither disturbs a correct unlock. Because the field reset value is an input, the bench can reset the block once with the secured code 2'b11 and once with 2'b00. That shows the unlock forces 2'b10 from any starting code and that reset reloads the field each time.

// File: rtl/sec_key_pkg.sv
package sec_key_pkg;

    typedef logic [1:0] sec_field_t;

    localparam sec_field_t SEC_OPEN = 2'b10;

    typedef struct packed {
        logic exit;
        logic pass;
    } verdict_t;

    function automatic logic is_open(sec_field_t s);
        return s == SEC_OPEN;
    endfunction

endpackage

// File: rtl/sec_key_capture.sv
module sec_key_capture #(
    parameter int KEY_W    = 16,
    parameter int NUM_KEYS = 4,
    parameter int ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFF00
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_i,
    input  logic                      clr_i,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [KEY_W-1:0]          wr_data_i,
    output logic [NUM_KEYS*KEY_W-1:0] keys_o,
    output logic [NUM_KEYS-1:0]       seen_o
);
    localparam int IDX_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;
    localparam int WIN_LO = IDX_W + 1;

    logic             hit;
    logic [IDX_W-1:0] idx;

    assign idx = wr_addr_i[IDX_W:1];
    assign hit = acc_i && wr_en_i && !wr_addr_i[0]
              && (wr_addr_i[ADDR_W-1:WIN_LO] == KEY_BASE[ADDR_W-1:WIN_LO]);

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                keys_o[k*KEY_W +: KEY_W] <= '0;
                seen_o[k]                <= 1'b0;
            end else if (hit && idx == IDX_W'(k)) begin
                keys_o[k*KEY_W +: KEY_W] <= wr_data_i;
                seen_o[k]                <= 1'b1;
            end
        end
    end

    AST_CLEARED_AFTER_COMPARE: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (seen_o == '0)); // R7

    AST_NO_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!acc_i && !clr_i) |=> $stable(seen_o)); // R6

endmodule

// File: rtl/sec_key_compare.sv
module sec_key_compare #(
    parameter int KEY_W    = 16,
    parameter int NUM_KEYS = 4
) (
    input  logic                      key_en_i,
    input  logic [NUM_KEYS*KEY_W-1:0] keys_i,
    input  logic [NUM_KEYS*KEY_W-1:0] stored_i,
    input  logic [NUM_KEYS-1:0]       seen_i,
    output logic                      pass_o
);
    logic [NUM_KEYS-1:0] match;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_cmp
        assign match[k] = seen_i[k]
                       && (keys_i[k*KEY_W +: KEY_W] == stored_i[k*KEY_W +: KEY_W]);
    end

    assign pass_o = key_en_i && (&match);

endmodule

// File: rtl/sec_state_ctrl.sv
module sec_state_ctrl
    import sec_key_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sec_field_t sec_rst_i,
    input  verdict_t   verdict_i,
    output sec_field_t sec_o,
    output logic       viol_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sec_o  <= sec_rst_i;
            viol_o <= 1'b0;
        end else begin
            viol_o <= verdict_i.exit && !verdict_i.pass;
            if (verdict_i.exit && verdict_i.pass)
                sec_o <= SEC_OPEN;
        end
    end

    AST_VIOL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        viol_o |=> !viol_o); // R11

    AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
        is_open(sec_o) |=> is_open(sec_o)); // R10

    AST_FAIL_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (verdict_i.exit && !verdict_i.pass) |=> $stable(sec_o)); // R3

endmodule

// File: rtl/sec_backdoor_unlock.sv
module sec_backdoor_unlock
    import sec_key_pkg::*;
#(
    parameter int KEY_W    = 16,
    parameter int NUM_KEYS = 4,
    parameter int ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFF00
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      key_en_i,
    input  logic [1:0]                sec_reset_i,
    input  logic                      key_acc_i,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [KEY_W-1:0]          wr_data_i,
    input  logic [NUM_KEYS*KEY_W-1:0] stored_keys_i,
    output logic [1:0]                sec_state_o,
    output logic                      violation_o
);
    logic                      acc_q;
    logic                      exit_now;
    logic                      pass;
    logic [NUM_KEYS*KEY_W-1:0] cap_keys;
    logic [NUM_KEYS-1:0]       cap_seen;
    verdict_t                  verdict;

    always_ff @(posedge clk) begin
        if (rst) acc_q <= 1'b0;
        else     acc_q <= key_acc_i;
    end

    assign exit_now     = acc_q && !key_acc_i;
    assign verdict.exit = exit_now;
    assign verdict.pass = pass;

    sec_key_capture #(
        .KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .ADDR_W(ADDR_W), .KEY_BASE(KEY_BASE)
    ) u_capture (
        .clk(clk), .rst(rst), .acc_i(key_acc_i), .clr_i(exit_now),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .keys_o(cap_keys), .seen_o(cap_seen)
    );

    sec_key_compare #(
        .KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS)
    ) u_compare (
        .key_en_i(key_en_i), .keys_i(cap_keys), .stored_i(stored_keys_i),
        .seen_i(cap_seen), .pass_o(pass)
    );

    sec_state_ctrl u_state (
        .clk(clk), .rst(rst), .sec_rst_i(sec_reset_i), .verdict_i(verdict),
        .sec_o(sec_state_o), .viol_o(violation_o)
    );

    AST_NO_OPEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (exit_now && !key_en_i && !is_open(sec_state_o)) |=> !is_open(sec_state_o)); // R5

    AST_VIOL_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
        violation_o |-> $past(exit_now)); // R11

    AST_MISSING_FAILS: assert property (@(posedge clk) disable iff (rst)
        (exit_now && !(&cap_seen)) |=> violation_o); // R4

endmodule

// File: tb/sec_backdoor_unlock_tb.sv
module sec_backdoor_unlock_tb_top;

    localparam int KEY_W = 16;
    localparam int NK    = 4;
    localparam int AW    = 16;
    localparam logic [AW-1:0] BASE = 16'hFF00;

    logic          clk = 1'b0;
    logic          rst;
    logic          key_en;
    logic [1:0]    sec_rst;
    logic          key_acc;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic [63:0]   stored;
    logic [1:0]    sec_state;
    logic          viol;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    sec_backdoor_unlock dut_i (
        .clk(clk), .rst(rst), .key_en_i(key_en), .sec_reset_i(sec_rst),
        .key_acc_i(key_acc), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .stored_keys_i(stored),
        .sec_state_o(sec_state), .violation_o(viol)
    );

    function automatic logic [15:0] key_of(int i);
        return stored[i*16 +: 16];
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [1:0] code);
        @(negedge clk);
        rst = 1'b1; sec_rst = code; key_acc = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sec during reset", 8'(sec_state), 8'(code));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sec after reset", 8'(sec_state), 8'(code));
        chk("R1 viol after reset", 8'(viol), 8'd0);
    endtask

    task automatic enter();
        @(negedge clk);
        key_acc = 1'b1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic leave(string req, logic [1:0] exp_sec, logic exp_viol);
        @(negedge clk);
        key_acc = 1'b0;
        @(negedge clk);
        chk({req, " sec"}, 8'(sec_state), 8'(exp_sec));
        chk({req, " viol"}, 8'(viol), 8'(exp_viol));
        @(negedge clk);
        chk({req, " R11 viol drops"}, 8'(viol), 8'd0);
    endtask

    task automatic t_wrong_word();
        enter();
        for (int i = 0; i < NK; i++)
            wr(BASE + AW'(2*i), (i == 2) ? 16'h0BAD : key_of(i));
        leave("R3 wrong word", 2'b11, 1'b1);
    endtask

    task automatic t_missing_word();
        enter();
        for (int i = 0; i < 3; i++) wr(BASE + AW'(2*i), key_of(i));
        leave("R4 missing word", 2'b11, 1'b1);
    endtask

    task automatic t_write_outside_mode();
        wr(BASE, key_of(0));
        chk("R6 no viol on idle write", 8'(viol), 8'd0);
        enter();
        for (int i = 1; i < NK; i++) wr(BASE + AW'(2*i), key_of(i));
        leave("R6 idle write ignored", 2'b11, 1'b1);
    endtask

    task automatic t_key_disabled();
        key_en = 1'b0;
        enter();
        for (int i = 0; i < NK; i++) wr(BASE + AW'(2*i), key_of(i));
        leave("R5 key disabled", 2'b11, 1'b1);
        key_en = 1'b1;
    endtask

    task automatic t_cleared();
        enter();
        for (int i = 0; i < 3; i++) wr(BASE + AW'(2*i), key_of(i));
        leave("R7 cleared after compare", 2'b11, 1'b1);
    endtask

    task automatic t_unlock_with_noise();
        enter();
        wr(BASE + 16'd2, 16'hDEAD);
        for (int i = 0; i < NK; i++) wr(BASE + AW'(2*i), key_of(i));
        wr(BASE + 16'd3, 16'h0000);
        wr(BASE + 16'd8, 16'h0000);
        chk("R8 no viol in mode", 8'(viol), 8'd0);
        leave("R2 R8 R9 unlock", 2'b10, 1'b0);
    endtask

    task automatic t_sticky();
        enter();
        wr(BASE, 16'h1234);
        leave("R10 sticky open", 2'b10, 1'b1);
    endtask

    task automatic t_unlock_from_zero();
        do_reset(2'b00);
        enter();
        for (int i = NK - 1; i >= 0; i--) wr(BASE + AW'(2*i), key_of(i));
        leave("R2 unlock from 00", 2'b10, 1'b0);
    endtask

    initial begin
        rst = 1'b1; key_en = 1'b1; sec_rst = 2'b11; key_acc = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        stored = 64'hC0DE_7A5E_91B3_4F28;
        do_reset(2'b11);
        t_wrong_word();
        t_missing_word();
        t_write_outside_mode();
        t_key_disabled();
        t_cleared();
        t_unlock_with_noise();
        t_sticky();
        do_reset(2'b11);
        t_unlock_from_zero();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule